// File: doc/BRIEF.md
# Multi-Offset Sum-of-Absolute-Differences Unit

This unit computes eight sums of absolute differences over unsigned bytes in a single operation. A 4-byte reference group is picked from the source operand. An 11-byte region is picked from the destination operand. Each of the eight output lanes compares the reference group against a 4-byte window of that region. Window k starts k bytes further along the region, so the eight lanes cover every alignment of the reference within the region, and the input never has to be realigned first.

For blocks larger than 4×4, software runs the unit several times with different selector values. Each pass adds its new sums to the previous 8×16-bit result, and the addition saturates at 65535. Operands enter through a valid/ready handshake. The result is registered one cycle after acceptance and is held until the consumer takes it. A new input is accepted while the output register is empty, or in the same cycle that the consumer drains it (in_ready = !out_valid || out_ready). A stalled output therefore stalls the input one-for-one, and no data is lost or duplicated.

Byte j of a 128-bit operand occupies bits 8j+7:8j.

Top module: `msad_unit`

## Requirements
- R1: in_ready is 1 whenever out_valid is 0 or out_ready is 1, and 0 while out_valid is 1 and out_ready is 0. An input is accepted on a clock edge where in_valid and in_ready are both 1.
- R2: out_valid is 1 in the cycle after an input is accepted. While out_valid is 1 and out_ready is 0, out_valid and out_sums hold their values. Results leave in the order their inputs were accepted.
- R3: With imm[1:0] = g, the reference group is source bytes 4g through 4g+3.
- R4: The region start s is 0 when imm[2] = 0 and 4 when imm[2] = 1. Lane k (k = 0..7) compares destination bytes s+k through s+k+3 against the reference, pairing destination byte s+k+i with reference byte i.
- R5: Lane k occupies out_sums bits 16k+15:16k. With acc_en = 0, it holds the sum of the four absolute byte differences, zero-extended, so the largest value is 1020 (0x03FC).
- R6: With acc_en = 1, lane k is min(acc_prev lane k + new sum, 65535), using the same lane placement in acc_prev.
- R7: With acc_en = 0, acc_prev has no effect on out_sums.
- R8: imm bits 7:3 have no effect on out_sums.
- R9: After reset, out_valid is 0, out_sums is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand set is offered |
| in_ready | output | 1 | Unit can take an operand set this cycle |
| dst_op | input | 128 | Operand supplying the sliding region |
| src_op | input | 128 | Operand supplying the fixed reference group |
| imm | input | 8 | Selector: bits 1:0 pick the reference group, bit 2 picks the region, bits 7:3 unused |
| acc_en | input | 1 | Add the new sums to acc_prev with saturation |
| acc_prev | input | 128 | Previous eight 16-bit lane results |
| out_valid | output | 1 | out_sums holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_sums | output | 128 | Eight 16-bit lane results |

## Verification
A wrong window offset or reference selection inside the datapath shows up as wrong lane values in the first result after the affected input, one cycle after acceptance. A fault in the saturation or accumulate path shows up only in lanes whose sum crosses 65535, or whose acc_prev is nonzero, so those boundary values are driven on purpose. A fault in the output register's valid or hold state shows up as a dropped, duplicated or changed result while out_ready is low. Such a fault is caught at the next negative clock edge, where every held result is compared against the bench's queue of expected results.

// File: rtl/msad_pkg.sv
package msad_pkg;
  localparam int unsigned BYTE_W_D = 8;
  localparam int unsigned GRP_D    = 4;
  localparam int unsigned LANES_D  = 8;
  localparam int unsigned SUM_W_D  = 16;
  localparam int unsigned OPD_B_D  = 16;

  // Number of bytes a sliding region spans for a given lane count.
  function automatic int unsigned region_bytes(input int unsigned lanes,
                                               input int unsigned grp);
    return lanes + grp - 1;
  endfunction
endpackage

// File: rtl/msad_window_sel.sv
module msad_window_sel
  import msad_pkg::*;
#(
  parameter int unsigned BYTE_W = BYTE_W_D,
  parameter int unsigned GRP    = GRP_D,
  parameter int unsigned LANES  = LANES_D,
  parameter int unsigned OPD_B  = OPD_B_D
) (
  input  logic [OPD_B*BYTE_W-1:0]       dst_i,
  input  logic [OPD_B*BYTE_W-1:0]       src_i,
  input  logic [1:0]                    grp_sel_i,
  input  logic                          region_hi_i,
  output logic [GRP*BYTE_W-1:0]         ref_o,
  output logic [LANES*GRP*BYTE_W-1:0]   win_o
);
  localparam int unsigned OPD_W    = OPD_B * BYTE_W;
  localparam int unsigned GRP_W    = GRP * BYTE_W;
  localparam int unsigned REGION_B = region_bytes(LANES, GRP);
  localparam int unsigned REGION_W = REGION_B * BYTE_W;

  logic [OPD_W-1:0]    src_shift;
  logic [OPD_W-1:0]    dst_shift;
  logic [REGION_W-1:0] region;

  // Reference group: shift the chosen group down to byte 0.
  always_comb begin
    src_shift = src_i >> (int'(grp_sel_i) * GRP_W);
    ref_o     = src_shift[GRP_W-1:0];
  end

  // Region: starts at byte 0 or at byte GRP.
  always_comb begin
    dst_shift = region_hi_i ? (dst_i >> GRP_W) : dst_i;
    region    = dst_shift[REGION_W-1:0];
  end

  // Each lane's window is one byte further along the region.
  for (genvar k = 0; k < LANES; k++) begin : g_win
    assign win_o[k*GRP_W +: GRP_W] = region[k*BYTE_W +: GRP_W];
  end
endmodule

// File: rtl/msad_lane.sv
module msad_lane
  import msad_pkg::*;
#(
  parameter int unsigned BYTE_W = BYTE_W_D,
  parameter int unsigned GRP    = GRP_D,
  parameter int unsigned SUM_W  = SUM_W_D
) (
  input  logic [GRP*BYTE_W-1:0] win_i,
  input  logic [GRP*BYTE_W-1:0] ref_i,
  input  logic                  acc_en_i,
  input  logic [SUM_W-1:0]      prev_i,
  output logic [SUM_W-1:0]      lane_o
);
  localparam int unsigned RAW_W   = BYTE_W + $clog2(GRP);
  localparam int unsigned RAW_MAX = GRP * ((1 << BYTE_W) - 1);

  logic [BYTE_W-1:0] diff [GRP];
  logic [RAW_W-1:0]  raw;
  logic [SUM_W:0]    wide;

  for (genvar g = 0; g < GRP; g++) begin : g_diff
    logic [BYTE_W-1:0] a_b, r_b;
    assign a_b     = win_i[g*BYTE_W +: BYTE_W];
    assign r_b     = ref_i[g*BYTE_W +: BYTE_W];
    assign diff[g] = (a_b >= r_b) ? (a_b - r_b) : (r_b - a_b);
  end

  always_comb begin
    raw = '0;
    for (int g = 0; g < GRP; g++) raw = raw + RAW_W'(diff[g]);
  end

  // Saturating accumulate: one carry bit beyond the lane width.
  always_comb begin
    wide = {1'b0, prev_i} + (SUM_W+1)'(raw);
    if (acc_en_i) lane_o = wide[SUM_W] ? '1 : wide[SUM_W-1:0];
    else          lane_o = SUM_W'(raw);
  end

  always_comb begin
    p_raw_bound_r5: assert (raw <= RAW_W'(RAW_MAX));
    if (acc_en_i) begin
      p_no_wrap_r6: assert (lane_o >= prev_i);
    end
  end
endmodule

// File: rtl/msad_out_stage.sv
module msad_out_stage #(
  parameter int unsigned W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] d_i,
  input  logic         out_ready_i,
  output logic         out_valid_o,
  output logic [W-1:0] q_o
);
  logic take;

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign take       = in_valid_i && in_ready_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      q_o         <= '0;
    end else begin
      if (take) begin
        out_valid_o <= 1'b1;
        q_o         <= d_i;
      end else if (out_ready_i) begin
        out_valid_o <= 1'b0;
      end
    end
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && in_ready_o) |=> out_valid_o);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(q_o)));

  p_drain_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_ready_i && !in_valid_i) |=> !out_valid_o);
endmodule

// File: rtl/msad_unit.sv
module msad_unit
  import msad_pkg::*;
#(
  parameter int unsigned BYTE_W = BYTE_W_D,
  parameter int unsigned GRP    = GRP_D,
  parameter int unsigned LANES  = LANES_D,
  parameter int unsigned SUM_W  = SUM_W_D,
  parameter int unsigned OPD_B  = OPD_B_D
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [OPD_B*BYTE_W-1:0]  dst_op,
  input  logic [OPD_B*BYTE_W-1:0]  src_op,
  input  logic [7:0]               imm,
  input  logic                     acc_en,
  input  logic [LANES*SUM_W-1:0]   acc_prev,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [LANES*SUM_W-1:0]   out_sums
);
  localparam int unsigned GRP_W = GRP * BYTE_W;
  localparam int unsigned RES_W = LANES * SUM_W;

  logic [GRP_W-1:0]       ref_grp;
  logic [LANES*GRP_W-1:0] windows;
  logic [RES_W-1:0]       next_sums;
  logic                   unused_imm_hi;

  assign unused_imm_hi = ^imm[7:3];

  msad_window_sel #(
    .BYTE_W(BYTE_W), .GRP(GRP), .LANES(LANES), .OPD_B(OPD_B)
  ) u_sel (
    .dst_i       (dst_op),
    .src_i       (src_op),
    .grp_sel_i   (imm[1:0]),
    .region_hi_i (imm[2]),
    .ref_o       (ref_grp),
    .win_o       (windows)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    msad_lane #(
      .BYTE_W(BYTE_W), .GRP(GRP), .SUM_W(SUM_W)
    ) u_lane (
      .win_i    (windows[k*GRP_W +: GRP_W]),
      .ref_i    (ref_grp),
      .acc_en_i (acc_en),
      .prev_i   (acc_prev[k*SUM_W +: SUM_W]),
      .lane_o   (next_sums[k*SUM_W +: SUM_W])
    );
  end

  msad_out_stage #(.W(RES_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .d_i         (next_sums),
    .out_ready_i (out_ready),
    .out_valid_o (out_valid),
    .q_o         (out_sums)
  );
endmodule

// File: tb/sim_msad_unit.sv
`timescale 1ns/1ps
module sim_msad_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] dst_op = '0;
  logic [127:0] src_op = '0;
  logic [7:0]   imm = '0;
  logic         acc_en = 1'b0;
  logic [127:0] acc_prev = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_sums;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit stall_mode = 1'b0;
  bit done = 1'b0;
  string cur_tag = "";

  logic [127:0] exp_q[$];
  string        tag_q[$];
  bit           pushed_last = 1'b0;

  always #4 clk = ~clk;

  msad_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .dst_op(dst_op), .src_op(src_op), .imm(imm), .acc_en(acc_en),
    .acc_prev(acc_prev), .out_valid(out_valid), .out_ready(out_ready),
    .out_sums(out_sums)
  );

  function automatic logic [127:0] model(input logic [127:0] d, input logic [127:0] s,
                                         input logic [7:0] im, input bit ac,
                                         input logic [127:0] pv);
    logic [127:0] res;
    int r0, s0;
    res = '0;
    r0 = int'(im[1:0]) * 4;
    s0 = im[2] ? 4 : 0;
    for (int k = 0; k < 8; k++) begin
      int sum, v;
      sum = 0;
      for (int i = 0; i < 4; i++) begin
        int a, b;
        a = int'(d[(s0+k+i)*8 +: 8]);
        b = int'(s[(r0+i)*8 +: 8]);
        sum += (a > b) ? (a - b) : (b - a);
      end
      v = ac ? (int'(pv[16*k +: 16]) + sum) : sum;
      if (v > 65535) v = 65535;
      res[16*k +: 16] = 16'(v);
    end
    return res;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Monitor: every negedge, away from the active edge.
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      // R1: ready rule
      check(in_ready == (!out_valid || out_ready), "R1 in_ready",
            128'(in_ready), 128'(!out_valid || out_ready));
      // R2: valid one cycle after acceptance
      if (pushed_last)
        check(out_valid == 1'b1, "R2 latency", 128'(out_valid), 128'(1));
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected output", out_sums, '0);
        end else begin
          check(out_sums == exp_q[0], {tag_q[0], " lane data"}, out_sums, exp_q[0]);
          if (out_ready) begin
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
          end
        end
      end
      pushed_last = in_valid && in_ready;
      if (pushed_last) begin
        exp_q.push_back(model(dst_op, src_op, imm, acc_en, acc_prev));
        tag_q.push_back(cur_tag);
      end
    end
  end

  // Consumer back-pressure.
  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  // Watchdog.
  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic send(input logic [127:0] d, input logic [127:0] s, input logic [7:0] im,
                      input bit ac, input logic [127:0] pv, input string tag);
    @(posedge clk); #1;
    in_valid = 1'b1; dst_op = d; src_op = s; imm = im; acc_en = ac; acc_prev = pv;
    cur_tag = tag;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  function automatic logic [127:0] lanes_of(input int v);
    logic [127:0] r;
    for (int k = 0; k < 8; k++) r[16*k +: 16] = 16'(v);
    return r;
  endfunction

  logic [127:0] pd, ps;

  initial begin
    for (int j = 0; j < 16; j++) begin
      ps[j*8 +: 8] = 8'(j * 17);
      pd[j*8 +: 8] = 8'(j * 29 + 100);
    end
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    check(out_valid == 1'b0, "R9 out_valid", 128'(out_valid), '0);
    check(out_sums == '0, "R9 out_sums", out_sums, '0);
    check(in_ready == 1'b1, "R9 in_ready", 128'(in_ready), 128'(1));
    @(posedge clk); #1 rst_n = 1'b1;

    // R3: reference group selection
    for (int g = 0; g < 4; g++) send(pd, ps, 8'(g), 1'b0, '0, "R3");
    // R4: region start selection
    for (int g = 4; g < 8; g++) send(pd, ps, 8'(g), 1'b0, '0, "R4");
    // R5: maximum per-lane sum 1020 in every lane
    send({16{8'hFF}}, '0, 8'h00, 1'b0, '0, "R5");
    send('0, {16{8'hFF}}, 8'h07, 1'b0, '0, "R5");
    // R6: saturation boundaries
    send({16{8'hFF}}, '0, 8'h00, 1'b1, lanes_of(64515), "R6 exact-max");
    send({16{8'hFF}}, '0, 8'h00, 1'b1, lanes_of(65000), "R6 saturate");
    send(pd, ps, 8'h05, 1'b1, lanes_of(65535), "R6 full-prev");
    send(pd, ps, 8'h02, 1'b1, {$urandom, $urandom, $urandom, $urandom}, "R6 random-prev");
    // R7: prev ignored without accumulate
    send(pd, ps, 8'h01, 1'b0, '1, "R7");
    // R8: upper immediate bits ignored
    send(pd, ps, 8'hF9, 1'b0, '0, "R8");
    send(pd, ps, 8'h2E, 1'b0, '0, "R8");

    // Random traffic under back-pressure (R1, R2 ordering and hold).
    stall_mode = 1'b1;
    for (int n = 0; n < 150; n++) begin
      send({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
           8'($urandom), 1'($urandom), {$urandom, $urandom, $urandom, $urandom}, "R2 random");
    end
    stall_mode = 1'b0;
    while (exp_q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule